// File: doc/BRIEF.md
# Floating-Point Exponent-to-Integer Extractor

This block takes one IEEE binary floating-point operand and returns its unbiased base-2 exponent as an exact signed integer. The integer has the same width as the element (16, 32 or 64 bits) and is sign-extended into a 64-bit result. A 2-bit size code selects the format. Subnormal operands are resolved exactly by counting the leading zeros of the fraction. Infinity, zero and NaN map to the saturated integer extremes.

The block is meant to sit as one lane of a wider floating-point pipeline. Each accepted operation leaves its result one clock after the input strobe, and a new operation may be issued every cycle. A lane predicate lets the result pass through an old destination value unchanged. Two flush-to-zero controls are provided: one for half precision and one for the wider formats. Invalid-operation and input-denormal events are reported per operation. They are also accumulated in sticky status bits until a synchronous clear.

Top module: `fp_logb_unit`

## Requirements
- R1: For a normal operand, the result is the exponent field minus the bias, sign-extended to 64 bits. A normal operand has an exponent field that is neither all zeros nor all ones. Size code 1 is half precision: exponent bits 14:10, bias 15, fraction bits 9:0. Size code 2 is single precision: bits 30:23, bias 127, fraction 22:0. Size code 3 is double precision: bits 62:52, bias 1023, fraction 51:0. The sign bit and all bits above the element are ignored.
- R2: For a subnormal operand with flush-to-zero off, the result is minus the bias minus the number of leading zeros of the left-aligned fraction. For example, a half fraction of 10'b1000000000 gives -15. No flag is raised.
- R3: For infinity (exponent all ones, fraction zero), the result is the largest positive integer of the element width, and no flag is raised.
- R4: For zero or NaN, the result is the most negative integer of the element width, and the invalid flag is raised.
- R5: For a subnormal operand with flush-to-zero on, both the denormal flag and the invalid flag are raised, and the result is the most negative integer.
- R6: Half precision takes its flush-to-zero control from `ftz_half`. Single and double precision take it from `ftz`.
- R7: Size code 0 is illegal. Such a request pulses `size_err` one cycle later, leaves `out_valid` low, and leaves `result` and the flags unchanged.
- R8: With `lane_active` low, an accepted operation returns `merge_val` as its result and raises no flag.
- R9: `sticky_invalid` and `sticky_denorm` accumulate the per-operation flags. A clock edge with `flag_clr` high clears them, and the clear takes priority over flags arriving on that same edge.
- R10: `out_valid`, `result` and the per-operation flags appear exactly one clock after `in_valid`. One operation is accepted every cycle, and `out_valid` is low after a cycle with no request.
- R11: During reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request strobe |
| size_sel | input | 2 | Format: 1 half, 2 single, 3 double, 0 illegal |
| operand | input | 64 | Floating-point operand, right-aligned |
| lane_active | input | 1 | Lane predicate; low selects merge |
| merge_val | input | 64 | Old destination value for inactive lanes |
| ftz | input | 1 | Flush-to-zero for single and double |
| ftz_half | input | 1 | Flush-to-zero for half precision |
| flag_clr | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Sign-extended integer exponent |
| size_err | output | 1 | Illegal size code seen on previous cycle |
| op_invalid | output | 1 | Invalid-operation flag of this result |
| op_denorm | output | 1 | Input-denormal flag of this result |
| sticky_invalid | output | 1 | Accumulated invalid flag |
| sticky_denorm | output | 1 | Accumulated denormal flag |

## Verification
The bench goes after the boundaries between operand classes. The smallest and largest normal exponents are checked, where an off-by-one bias would shift results by one. Subnormals with the leading one in every fraction position are checked, where a miscounted leading-zero vector gives a result off by the count. The format extremes are checked, where a design that saturates at 64-bit values instead of the element width would emit the wrong integer for half or single. The bench also crosses the two flush-to-zero controls with the size code. Swapping them would flush the wrong format. It mixes predicated-off lanes, illegal sizes and clears landing on flag-raising operations, where a design that lets flags leak, overwrites the result or lets accumulation beat the clear would disagree with the model.

// File: rtl/fplogb_pkg.sv
package fplogb_pkg;

  localparam int unsigned DATA_W = 64;

  typedef enum logic [1:0] {
    SZ_ILLEGAL = 2'd0,
    SZ_HALF    = 2'd1,
    SZ_SINGLE  = 2'd2,
    SZ_DOUBLE  = 2'd3
  } fsize_e;

  typedef struct packed {
    logic [DATA_W-1:0] value;
    logic              invalid;
    logic              denorm;
  } logb_out_t;

  // Exponent field width for a format index (1 half, 2 single, 3 double).
  function automatic int unsigned exp_bits(int unsigned idx);
    case (idx)
      1:       return 5;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  // Fraction field width for a format index.
  function automatic int unsigned frac_bits(int unsigned idx);
    case (idx)
      1:       return 10;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

  // Integer result width for a format index.
  function automatic int unsigned elem_bits(int unsigned idx);
    return 16 << (idx - 1);
  endfunction

  // Largest positive signed integer of a given width, sign-extended to 64 bits.
  function automatic logic [DATA_W-1:0] sat_max(int unsigned w);
    return (64'd1 << (w - 1)) - 64'd1;
  endfunction

  // Most negative signed integer of a given width, sign-extended.
  function automatic logic [DATA_W-1:0] sat_min(int unsigned w);
    return ~sat_max(w);
  endfunction

endpackage

// File: rtl/fplogb_lzc.sv
module fplogb_lzc #(
  parameter int unsigned W  = 10,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  // Scan upward; the highest set bit writes last and sets the count.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fplogb_fmt.sv
module fplogb_fmt
  import fplogb_pkg::*;
#(
  parameter int unsigned EW = 5,
  parameter int unsigned FW = 10,
  parameter int unsigned RW = 16,
  localparam int unsigned CW   = $clog2(FW + 1),
  localparam int unsigned BIAS = (1 << (EW - 1)) - 1
) (
  input  logic [EW+FW-1:0] bits_in,
  input  logic             flush,
  output logb_out_t        res
);
  logic [EW-1:0] expo;
  logic [FW-1:0] frac;
  logic [CW-1:0] lz;
  logic          exp_zero, exp_ones, frac_zero;

  assign expo      = bits_in[EW+FW-1:FW];
  assign frac      = bits_in[FW-1:0];
  assign exp_zero  = (expo == '0);
  assign exp_ones  = (expo == '1);
  assign frac_zero = (frac == '0);

  fplogb_lzc #(.W(FW), .CW(CW)) u_lzc (
    .vec   (frac),
    .count (lz)
  );

  always_comb begin
    res.value   = sat_min(RW);
    res.invalid = 1'b0;
    res.denorm  = 1'b0;
    if (exp_zero) begin
      if (!frac_zero && !flush) begin
        res.value = 64'(0) - 64'(BIAS) - 64'(lz);
      end else begin
        res.denorm  = !frac_zero;
        res.invalid = 1'b1;
      end
    end else if (exp_ones) begin
      if (frac_zero) res.value = sat_max(RW);
      else           res.invalid = 1'b1;
    end else begin
      res.value = 64'(expo) - 64'(BIAS);
    end
  end
endmodule

// File: rtl/fp_logb_unit.sv
module fp_logb_unit
  import fplogb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  size_sel,
  input  logic [63:0] operand,
  input  logic        lane_active,
  input  logic [63:0] merge_val,
  input  logic        ftz,
  input  logic        ftz_half,
  input  logic        flag_clr,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        size_err,
  output logic        op_invalid,
  output logic        op_denorm,
  output logic        sticky_invalid,
  output logic        sticky_denorm
);
  localparam int unsigned NFMT = 3;

  logb_out_t fmt_out [NFMT];
  logb_out_t sel_out;

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int unsigned EW = exp_bits(g + 1);
    localparam int unsigned FW = frac_bits(g + 1);
    localparam int unsigned RW = elem_bits(g + 1);
    logic flush_g;
    if (g == 0) begin : g_hflush
      assign flush_g = ftz_half;
    end else begin : g_mflush
      assign flush_g = ftz;
    end
    fplogb_fmt #(.EW(EW), .FW(FW), .RW(RW)) u_fmt (
      .bits_in (operand[EW+FW-1:0]),
      .flush   (flush_g),
      .res     (fmt_out[g])
    );
  end

  // Named events used by the datapath and visible to the checker.
  logic accept_req, illegal_req, raise_inv, raise_den;
  assign accept_req  = in_valid && (size_sel != SZ_ILLEGAL);
  assign illegal_req = in_valid && (size_sel == SZ_ILLEGAL);

  always_comb begin
    case (fsize_e'(size_sel))
      SZ_HALF:   sel_out = fmt_out[0];
      SZ_SINGLE: sel_out = fmt_out[1];
      SZ_DOUBLE: sel_out = fmt_out[2];
      default:   sel_out = '0;
    endcase
  end

  assign raise_inv = accept_req && lane_active && sel_out.invalid;
  assign raise_den = accept_req && lane_active && sel_out.denorm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      size_err       <= 1'b0;
      op_invalid     <= 1'b0;
      op_denorm      <= 1'b0;
      sticky_invalid <= 1'b0;
      sticky_denorm  <= 1'b0;
    end else begin
      out_valid <= accept_req;
      size_err  <= illegal_req;
      if (accept_req) begin
        result     <= lane_active ? sel_out.value : merge_val;
        op_invalid <= raise_inv;
        op_denorm  <= raise_den;
      end
      if (flag_clr) begin
        sticky_invalid <= 1'b0;
        sticky_denorm  <= 1'b0;
      end else begin
        sticky_invalid <= sticky_invalid | raise_inv;
        sticky_denorm  <= sticky_denorm  | raise_den;
      end
    end
  end
endmodule

// File: rtl/fplogb_checker.sv
module fplogb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  size_sel,
  input logic        lane_active,
  input logic [63:0] merge_val,
  input logic        flag_clr,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        size_err,
  input logic        op_invalid,
  input logic        op_denorm,
  input logic        sticky_invalid,
  input logic        sticky_denorm
);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel != 2'd0) |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !size_err);

  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'd0) |=> size_err && !out_valid && $stable(result));

  p_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel != 2'd0 && !lane_active) |=>
      (result == $past(merge_val)) && !op_invalid && !op_denorm);

  p_den_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_denorm |-> op_invalid);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !sticky_invalid && !sticky_denorm);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_invalid && !flag_clr) |=> sticky_invalid);

  p_accum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_invalid && !$past(flag_clr)) |-> sticky_invalid);
endmodule

bind fp_logb_unit fplogb_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .size_sel       (size_sel),
  .lane_active    (lane_active),
  .merge_val      (merge_val),
  .flag_clr       (flag_clr),
  .out_valid      (out_valid),
  .result         (result),
  .size_err       (size_err),
  .op_invalid     (op_invalid),
  .op_denorm      (op_denorm),
  .sticky_invalid (sticky_invalid),
  .sticky_denorm  (sticky_denorm)
);

// File: tb/tb_fp_logb_unit.sv
module tb_fp_logb_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  size_sel = 2'd1;
  logic [63:0] operand = '0;
  logic        lane_active = 1'b1;
  logic [63:0] merge_val = '0;
  logic        ftz = 1'b0;
  logic        ftz_half = 1'b0;
  logic        flag_clr = 1'b0;
  logic        out_valid, size_err, op_invalid, op_denorm, sticky_invalid, sticky_denorm;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [63:0] m_res = '0;
  bit m_inv = 0, m_den = 0, m_sinv = 0, m_sden = 0;

  always #5 clk = ~clk;

  fp_logb_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
    .operand(operand), .lane_active(lane_active), .merge_val(merge_val),
    .ftz(ftz), .ftz_half(ftz_half), .flag_clr(flag_clr),
    .out_valid(out_valid), .result(result), .size_err(size_err),
    .op_invalid(op_invalid), .op_denorm(op_denorm),
    .sticky_invalid(sticky_invalid), .sticky_denorm(sticky_denorm)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ewid(int s); return s == 1 ? 5 : (s == 2 ? 8 : 11); endfunction
  function automatic int fwid(int s); return s == 1 ? 10 : (s == 2 ? 23 : 52); endfunction

  // Model: value, invalid, denorm. Subnormal restated via position of top set bit.
  function automatic logic [65:0] model(int s, logic [63:0] op, bit fz);
    int ew = ewid(s);
    int fw = fwid(s);
    int rw = 16 << (s - 1);
    longint bias = (longint'(1) << (ew - 1)) - 1;
    longint e = longint'((op >> fw) & ((64'd1 << ew) - 1));
    logic [63:0] f = op & ((64'd1 << fw) - 1);
    longint maxv = (rw == 64) ? 64'h7fff_ffff_ffff_ffff : (longint'(1) << (rw - 1)) - 1;
    longint minv = -maxv - 1;
    longint allones = (longint'(1) << ew) - 1;
    int top = -1;
    for (int i = 0; i < fw; i++) if (f[i]) top = i;
    if (e == 0) begin
      if (f == 0) return {1'b0, 1'b1, 64'(minv)};
      if (fz) return {1'b1, 1'b1, 64'(minv)};
      return {1'b0, 1'b0, 64'(longint'(top) - fw + 1 - bias)};
    end
    if (e == allones) begin
      if (f == 0) return {1'b0, 1'b0, 64'(maxv)};
      return {1'b0, 1'b1, 64'(minv)};
    end
    return {1'b0, 1'b0, 64'(e - bias)};
  endfunction

  function automatic logic [63:0] pack(int s, bit sg, longint e, logic [63:0] f, logic [63:0] junk);
    int ew = ewid(s);
    int fw = fwid(s);
    int tw = ew + fw + 1;
    logic [63:0] v;
    v = (64'(e) << fw) | (f & ((64'd1 << fw) - 1));
    if (sg) v = v | (64'd1 << (ew + fw));
    if (tw < 64) v = v | (junk & ~((64'd1 << tw) - 1));
    return v;
  endfunction

  task automatic op(int s, logic [63:0] opnd, bit act, logic [63:0] mrg,
                    bit fz, bit fzh, bit clr, string req);
    logic [65:0] m;
    bit exp_ov, exp_se;
    in_valid = 1; size_sel = 2'(s); operand = opnd; lane_active = act;
    merge_val = mrg; ftz = fz; ftz_half = fzh; flag_clr = clr;
    exp_ov = (s != 0); exp_se = (s == 0);
    if (s != 0) begin
      m = model(s, opnd, (s == 1) ? fzh : fz);
      if (act) begin m_res = m[63:0]; m_inv = m[64]; m_den = m[65]; end
      else begin m_res = mrg; m_inv = 0; m_den = 0; end
    end
    if (clr) begin m_sinv = 0; m_sden = 0; end
    else if (s != 0) begin m_sinv = m_sinv | m_inv; m_sden = m_sden | m_den; end
    @(negedge clk);
    check(out_valid == exp_ov && size_err == exp_se, {req, "/R10 valid"},
          64'({out_valid, size_err}), 64'({exp_ov, exp_se}));
    check(result == m_res, {req, " result"}, result, m_res);
    check(op_invalid == m_inv && op_denorm == m_den, {req, " flags"},
          64'({op_invalid, op_denorm}), 64'({m_inv, m_den}));
    check(sticky_invalid == m_sinv && sticky_denorm == m_sden, {req, "/R9 sticky"},
          64'({sticky_invalid, sticky_denorm}), 64'({m_sinv, m_sden}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    check({out_valid, size_err, op_invalid, op_denorm, sticky_invalid, sticky_denorm} == 6'd0
          && result == 64'd0, "R11 reset", result, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R1 normal, bias edges per format, upper junk and sign ignored
    for (int s = 1; s <= 3; s++) begin
      op(s, pack(s, 0, 1, 64'h5, 64'hdead_beef_cafe_f00d), 1, 0, 0, 0, 0, "R1 min normal");
      op(s, pack(s, 1, (longint'(1) << ewid(s)) - 2, 64'h3, 64'hffff_ffff_ffff_ffff), 1, 0, 0, 0, 0, "R1 max normal");
      op(s, pack(s, 0, (longint'(1) << (ewid(s) - 1)) - 1, 0, 0), 1, 0, 0, 0, 0, "R1 bias");
      // R2 subnormal at every leading position
      for (int p = 0; p < fwid(s); p++)
        op(s, pack(s, p[0], 0, (64'd1 << p) | (64'(p) >> 1), 64'h1234_5678_9abc_def0), 1, 0, 0, 0, 0, "R2 subnormal");
      op(s, pack(s, 0, (longint'(1) << ewid(s)) - 1, 0, 0), 1, 0, 0, 0, 0, "R3 infinity");
      op(s, pack(s, 1, 0, 0, 0), 1, 0, 0, 0, 0, "R4 zero");
      op(s, pack(s, 0, (longint'(1) << ewid(s)) - 1, 64'h1, 0), 1, 0, 0, 0, 1, "R4 nan clr R9");
      op(s, pack(s, 0, 0, 64'h1, 0), 1, 0, 1, 1, 0, "R5 ftz subnormal");
      // R6: only the matching control flushes
      op(s, pack(s, 0, 0, 64'h2, 0), 1, 0, s == 1, s != 1, 1, "R6 other ftz ignored");
    end
    // R7 illegal size keeps result
    op(0, 64'h0, 1, 64'h55, 0, 0, 0, "R7 illegal");
    op(0, 64'h0, 1, 64'h55, 0, 0, 1, "R7 illegal clr");
    // R8 merge on inactive lane with a NaN input
    op(2, 64'h7fc0_0001, 0, 64'h0123_4567_89ab_cdef, 0, 0, 0, "R8 merge");
    // R9 clear wins over flag on same edge
    op(1, 64'h0, 1, 0, 0, 0, 1, "R9 clear priority");
    // R10 idle cycle
    in_valid = 0; flag_clr = 0;
    @(negedge clk);
    check(out_valid == 0 && size_err == 0, "R10 idle", 64'(out_valid), 64'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int s = int'($urandom_range(0, 3));
      int ek = int'($urandom_range(0, 3));
      longint e;
      logic [63:0] f = {$urandom, $urandom};
      int ew = ewid(s == 0 ? 1 : s);
      if (ek == 0) e = 0;
      else if (ek == 1) e = (longint'(1) << ew) - 1;
      else e = longint'($urandom_range(1, (1 << ew) - 2));
      if ($urandom_range(0, 3) == 0) f = 0;
      else if ($urandom_range(0, 1) == 0) f = f >> $urandom_range(0, 63);
      op(s, s == 0 ? {$urandom, $urandom} : pack(s, 1'($urandom), e, f, {$urandom, $urandom}),
         $urandom_range(0, 4) != 0, {$urandom, $urandom}, 1'($urandom), 1'($urandom),
         $urandom_range(0, 9) == 0, "R1-mix random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule